// File: doc/BRIEF.md
# Serial Converter Interface Emulator

This block reproduces the digital behaviour of a three-wire successive-approximation converter. It has no analog front end. An external host drives a serial clock and a convert-start line, and the block answers on a serial data line with a separate output enable. A parallel test port supplies the code that a real converter would produce, plus its two extra sub-bits. The block is meant as a stand-in for a real converter in system-level test, so that the host's framing, continuous-conversion timing and power-down sequencing can all be exercised.

A fast local clock samples the serial clock and the convert-start line and detects their edges. All state moves on those detected edges. The block counts rising serial-clock edges inside each frame and shifts out a 16-bit word. From the edge count at which convert-start returns high, it decides whether conversion stays continuous, whether the frame was aborted, or whether to step into a lower power state. It also reports whether the sampler is in hold or track, whether the reference would be powered, and whether the first (initialization) conversion has finished.

Top module: `serAdcEmu`

## Requirements
- R1: In normal mode, a falling edge of `cnvSt` latches the test inputs, puts `trackHold` in hold (1), sets `doutOe` to 1 and sets `dout` to 0.
- R2: The frame is `{3'b000, code[9:0], sub[1:0], 1'b0}`, sent MSB first. After the k-th rising `sclk` edge of a frame (k = 1..16), `dout` carries frame bit 16-k. The code MSB therefore appears after edge 4. `dout` changes only on rising `sclk` edges or on a `cnvSt` fall.
- R3: Changes on `testCode` and `testSub` after the `cnvSt` fall have no effect on the frame being sent.
- R4: If `cnvSt` rises when the edge count is 14 or 15, `doutOe` stays 1 and the rest of the frame is still shifted out.
- R5: If `cnvSt` is still low at the 16th falling `sclk` edge, `doutOe` drops at the next rising edge of `sclk` or of `cnvSt`, whichever comes first.
- R6: A `cnvSt` rise at an edge count from 3 to 13 moves `pwrMode` one step down: 0 (normal) goes to 1 (partial), and 1 goes to 2 (full). Full is entered only from partial.
- R7: In partial or full power-down, `doutOe` stays 0 whatever `sclk` and `cnvSt` do. `refEn` is 1 in normal and partial mode and 0 in full mode.
- R8: A `cnvSt` rise after at least 14 rising edges returns the block to normal mode from either power-down state. A shorter low period does not wake the block.
- R9: `trackHold` returns to track (0) at the 14th rising edge and at any `cnvSt` rise. It is in track after reset, and it enters hold only on a `cnvSt` fall.
- R10: `calibDone` is 0 after reset, becomes 1 at the 16th rising edge of the first frame started in normal mode, and stays 1 through power-down and wake.
- R11: After reset, `doutOe` = 0, `dout` = 0, `pwrMode` = 0, `refEn` = 1 and `trackHold` = 0.
- R12: A `cnvSt` rise at an edge count below 3 aborts the frame: `doutOe` = 0, track mode, and the power mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, faster than sclk |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cnvSt | input | 1 | Convert-start line, active low during a frame |
| testCode | input | 10 | Code to report for the next conversion |
| testSub | input | 2 | Sub-bits to report for the next conversion |
| dout | output | 1 | Serial data value |
| doutOe | output | 1 | Serial data enable (0 = high impedance) |
| trackHold | output | 1 | 1 = hold, 0 = track |
| refEn | output | 1 | Reference powered |
| pwrMode | output | 2 | 0 normal, 1 partial power-down, 2 full power-down |
| calibDone | output | 1 | First full conversion since reset finished |

## Verification
Frames carry all-ones, all-zeros and two alternating codes with every sub-bit value. This separates a correct MSB-first order from a reversed or shifted one, and it exposes a stuck or misplaced sub-bit or zero field. Each frame ends in one of three ways: continuous restart, a serial-clock rise after the 16th fall, or a convert-start rise. These endings separate the three rules that control the output enable. Convert-start is also returned high after 2, 5, 13, 14 and 16 edges, from each power mode, to tell abort, power-down stepping and wake apart.

// File: rtl/serAdcEmuPkg.sv
package serAdcEmuPkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_PARTIAL = 2'd1,
    MODE_FULL    = 2'd2
  } pwrMode_e;

  typedef struct packed {
    logic load;
    logic shift;
  } ctrlStrobes_t;
endpackage

// File: rtl/serAdcEmuCtrl.sv
module serAdcEmuCtrl
  import serAdcEmuPkg::*;
#(
  parameter int LEAD_W  = 3,
  parameter int FRAME_W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclk,
  input  logic         cnvSt,
  output ctrlStrobes_t strobes,
  output logic         doutOe,
  output logic         trackHold,
  output pwrMode_e     pwrMode,
  output logic         calibDone
);
  localparam int CNT_W = $clog2(2 * FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] PD_LO     = CNT_W'(LEAD_W);
  localparam logic [CNT_W-1:0] TRACK_AT  = CNT_W'(FRAME_W - 2);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_W);

  logic sclkQ, cnvQ;
  logic sclkRise, sclkFall, cnvRise, cnvFall;
  logic [CNT_W-1:0] edgeCnt, cntNext;
  logic inConv, fall16;
  logic contWindow, pdWindow;

  assign sclkRise = sclk & ~sclkQ;
  assign sclkFall = ~sclk & sclkQ;
  assign cnvRise  = cnvSt & ~cnvQ;
  assign cnvFall  = ~cnvSt & cnvQ;
  assign cntNext  = (edgeCnt == CNT_MAX) ? edgeCnt : edgeCnt + 1'b1;

  assign contWindow = (edgeCnt >= TRACK_AT) && (edgeCnt < FRAME_END);
  assign pdWindow   = (edgeCnt >= PD_LO) && (edgeCnt < TRACK_AT);

  always_comb begin
    strobes.load  = cnvFall;
    strobes.shift = !cnvFall && !cnvRise && sclkRise;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ     <= 1'b0;
      cnvQ      <= 1'b1;
      edgeCnt   <= '0;
      inConv    <= 1'b0;
      fall16    <= 1'b0;
      doutOe    <= 1'b0;
      trackHold <= 1'b0;
      pwrMode   <= MODE_NORMAL;
      calibDone <= 1'b0;
    end else begin
      sclkQ <= sclk;
      cnvQ  <= cnvSt;
      if (cnvFall) begin
        edgeCnt   <= '0;
        trackHold <= 1'b1;
        doutOe    <= (pwrMode == MODE_NORMAL);
        inConv    <= (pwrMode == MODE_NORMAL);
        fall16    <= 1'b0;
      end else if (cnvRise) begin
        trackHold <= 1'b0;
        fall16    <= 1'b0;
        if (pdWindow) begin
          doutOe  <= 1'b0;
          inConv  <= 1'b0;
          pwrMode <= (pwrMode == MODE_NORMAL) ? MODE_PARTIAL : MODE_FULL;
        end else if (edgeCnt >= TRACK_AT) begin
          pwrMode <= MODE_NORMAL;
          if (!contWindow) begin
            doutOe <= 1'b0;
            inConv <= 1'b0;
          end
        end else begin
          doutOe <= 1'b0;
          inConv <= 1'b0;
        end
      end else begin
        if (sclkRise) begin
          edgeCnt <= cntNext;
          if (cntNext == TRACK_AT) trackHold <= 1'b0;
          if (cntNext == FRAME_END && inConv) calibDone <= 1'b1;
          if (fall16) begin
            doutOe <= 1'b0;
            fall16 <= 1'b0;
          end
        end
        if (sclkFall && !cnvSt && edgeCnt == FRAME_END) fall16 <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serAdcEmuData.sv
module serAdcEmuData
  import serAdcEmuPkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SUB_W  = 2,
  parameter int LEAD_W = 3,
  parameter int TAIL_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [CODE_W-1:0] code,
  input  logic [SUB_W-1:0]  sub,
  output logic              dout
);
  localparam int FRAME_W = LEAD_W + CODE_W + SUB_W + TAIL_W;

  logic [FRAME_W-1:0] frameReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg <= '0;
      dout     <= 1'b0;
    end else if (strobes.load) begin
      frameReg <= {{LEAD_W{1'b0}}, code, sub, {TAIL_W{1'b0}}};
      dout     <= 1'b0;
    end else if (strobes.shift) begin
      dout     <= frameReg[FRAME_W-1];
      frameReg <= {frameReg[FRAME_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/serAdcEmu.sv
module serAdcEmu
  import serAdcEmuPkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SUB_W  = 2,
  parameter int LEAD_W = 3,
  parameter int TAIL_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              cnvSt,
  input  logic [CODE_W-1:0] testCode,
  input  logic [SUB_W-1:0]  testSub,
  output logic              dout,
  output logic              doutOe,
  output logic              trackHold,
  output logic              refEn,
  output logic [1:0]        pwrMode,
  output logic              calibDone
);
  localparam int FRAME_W = LEAD_W + CODE_W + SUB_W + TAIL_W;

  ctrlStrobes_t strobes;
  pwrMode_e     modeQ;

  serAdcEmuCtrl #(.LEAD_W(LEAD_W), .FRAME_W(FRAME_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .cnvSt(cnvSt),
    .strobes(strobes), .doutOe(doutOe), .trackHold(trackHold),
    .pwrMode(modeQ), .calibDone(calibDone)
  );

  serAdcEmuData #(.CODE_W(CODE_W), .SUB_W(SUB_W), .LEAD_W(LEAD_W), .TAIL_W(TAIL_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .code(testCode), .sub(testSub), .dout(dout)
  );

  assign pwrMode = modeQ;
  assign refEn   = (modeQ != MODE_FULL);
endmodule

// File: rtl/serAdcEmuChk.sv
module serAdcEmuChk (
  input logic       clk,
  input logic       rstN,
  input logic       sclk,
  input logic       cnvSt,
  input logic       dout,
  input logic       doutOe,
  input logic       trackHold,
  input logic [1:0] pwrMode,
  input logic       calibDone
);
  assert_start_drives_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cnvSt) && !$rose(sclk) && pwrMode == 2'd0) |=> (doutOe && !dout && trackHold));

  assert_dout_on_edges_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dout) |-> ($past($rose(sclk)) || $past($fell(cnvSt))));

  assert_full_from_partial_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMode == 2'd2 && $past(pwrMode) != 2'd2) |-> ($past(pwrMode) == 2'd1));

  assert_quiet_in_powerdown_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMode != 2'd0) |-> !doutOe);

  assert_hold_only_on_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trackHold) |-> $past($fell(cnvSt)));

  assert_calib_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(calibDone));
endmodule

bind serAdcEmu serAdcEmuChk uChk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .cnvSt(cnvSt), .dout(dout),
  .doutOe(doutOe), .trackHold(trackHold), .pwrMode(pwrMode), .calibDone(calibDone)
);

// File: tb/tb_serAdcEmu.sv
module tb_serAdcEmu;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic cnvSt = 1'b1;
  logic [9:0] testCode = '0;
  logic [1:0] testSub = '0;
  logic dout, doutOe, trackHold, refEn, calibDone;
  logic [1:0] pwrMode;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serAdcEmu dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .cnvSt(cnvSt),
    .testCode(testCode), .testSub(testSub), .dout(dout), .doutOe(doutOe),
    .trackHold(trackHold), .refEn(refEn), .pwrMode(pwrMode), .calibDone(calibDone)
  );

  // {endKind[1:0], sub[1:0], code[9:0]}; endKind 0 continuous, 1 sclk rise, 2 cnvSt rise
  localparam logic [13:0] VEC [0:5] = '{
    {2'd0, 2'b11, 10'h3FF},
    {2'd1, 2'b00, 10'h000},
    {2'd2, 2'b01, 10'h2AA},
    {2'd0, 2'b10, 10'h155},
    {2'd1, 2'b00, 10'h201},
    {2'd2, 2'b11, 10'h1FE}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic sclkUp();
    @(negedge clk); sclk = 1'b1; settle();
  endtask

  task automatic sclkDown();
    @(negedge clk); sclk = 1'b0; settle();
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sclkUp(); sclkDown();
    end
  endtask

  task automatic cnvSet(input logic v);
    @(negedge clk); cnvSt = v; settle();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    settle();
    // R11 reset state
    chk("R11 doutOe", doutOe, 0);
    chk("R11 dout", dout, 0);
    chk("R11 pwrMode", pwrMode, 0);
    chk("R11 refEn", refEn, 1);
    chk("R11 trackHold", trackHold, 0);
    chk("R10 calibDone after reset", calibDone, 0);

    for (int v = 0; v < 6; v++) begin
      logic [9:0] code;
      logic [1:0] sub;
      logic [1:0] endKind;
      logic [15:0] expFrame;
      {endKind, sub, code} = VEC[v];
      expFrame = {3'b000, code, sub, 1'b0};
      @(negedge clk); testCode = code; testSub = sub;
      cnvSet(1'b0);
      chk("R1 oe at start", doutOe, 1);
      chk("R1 dout low at start", dout, 0);
      chk("R1 hold at start", trackHold, 1);
      @(negedge clk); testCode = ~code; testSub = ~sub;  // R3: must not alter this frame
      for (int k = 1; k <= 16; k++) begin
        sclkUp();
        chk($sformatf("R2 R3 bit after edge %0d", k), dout, expFrame[16-k]);
        if (k == 13) chk("R9 still hold at edge 13", trackHold, 1);
        if (k == 14) chk("R9 track at edge 14", trackHold, 0);
        if (k == 16) chk("R10 calibDone after first frame", calibDone, 1);
        sclkDown();
        if (k == 14 && endKind == 2'd0) begin
          cnvSet(1'b1);
          chk("R4 oe kept after early rise", doutOe, 1);
        end
      end
      if (endKind == 2'd0) begin
        chk("R4 oe after continuous frame", doutOe, 1);
      end else if (endKind == 2'd1) begin
        chk("R5 oe before next sclk rise", doutOe, 1);
        sclkUp();
        chk("R5 oe off at sclk rise", doutOe, 0);
        sclkDown();
        cnvSet(1'b1);
      end else begin
        chk("R5 oe before cnvSt rise", doutOe, 1);
        cnvSet(1'b1);
        chk("R5 oe off at cnvSt rise", doutOe, 0);
      end
      chk("R6 mode stays normal", pwrMode, 0);
    end

    // R12 abort
    cnvSet(1'b0);
    pulses(2);
    cnvSet(1'b1);
    chk("R12 abort mode", pwrMode, 0);
    chk("R12 abort oe", doutOe, 0);
    chk("R12 abort track", trackHold, 0);

    // R6 into partial
    cnvSet(1'b0);
    pulses(5);
    cnvSet(1'b1);
    chk("R6 partial mode", pwrMode, 1);
    chk("R7 refEn in partial", refEn, 1);
    pulses(4);
    chk("R7 oe quiet with sclk in partial", doutOe, 0);
    cnvSet(1'b0);
    chk("R7 oe quiet on start in partial", doutOe, 0);
    pulses(5);
    cnvSet(1'b1);
    chk("R6 full mode", pwrMode, 2);
    chk("R7 refEn in full", refEn, 0);

    // R8 wake rules
    cnvSet(1'b0);
    pulses(13);
    cnvSet(1'b1);
    chk("R8 short low keeps full", pwrMode, 2);
    cnvSet(1'b0);
    pulses(14);
    chk("R7 oe quiet during wake frame", doutOe, 0);
    cnvSet(1'b1);
    chk("R8 wake from full", pwrMode, 0);
    chk("R8 refEn after wake", refEn, 1);
    chk("R10 calibDone kept over power-down", calibDone, 1);

    cnvSet(1'b0);
    pulses(5);
    cnvSet(1'b1);
    chk("R6 partial again", pwrMode, 1);
    cnvSet(1'b0);
    pulses(16);
    cnvSet(1'b1);
    chk("R8 wake from partial", pwrMode, 0);
    cnvSet(1'b0);
    chk("R1 oe on after wake", doutOe, 1);
    cnvSet(1'b1);

    finishRun();
  end
endmodule